// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block works next to a simple processor core and takes over the hardware part of interrupt handling. The core reports when an instruction has finished, and only at those boundaries does the block look at its level-sensitive request lines. When it accepts a request, it acknowledges that line with a one-cycle pulse. It pushes a frame holding the address of the next instruction, the program status word and the level then in service onto a small hardware control stack. It then tells the core to load the program counter with that line's handler entry address, which is taken from a writable per-line vector table.

A return command given at an instruction boundary pops the newest frame. The core reloads the saved address and status word, and the block restores the saved service level. The block runs in one of two modes. In the sequential mode, all requests are masked while any handler runs, and they stay pending until the return. In the nested mode, a request of strictly higher priority than the running handler preempts it. Line 0 has the highest priority. Overflow and underflow of the control stack are reported through sticky error flags.

Top module: `irq_sequencer`

## Requirements
- R1: After reset, all acknowledge lines, both load strobes and both error flags are 0, and the service level reads NUM_SRC, which means idle.
- R2: No request is acted on unless `insn_done` is high on that clock edge. Without it, `irq_ack`, `pc_load` and `psw_load` stay 0.
- R3: An accepted request produces, in the cycle after the boundary edge, a one-cycle pulse on exactly the `irq_ack` bit of the selected line, with `pc_load` high in the same cycle.
- R4: When several eligible lines request at once, the lowest line index is selected.
- R5: On entry, `pc_val` equals the vector table entry of the selected line. Entry i is written by `vec_we` with `vec_idx`=i and `vec_data` on a clock edge. On entry, `svc_lvl` becomes the line index.
- R6: `rti` together with `insn_done` pops the newest frame. In the next cycle, `pc_load` and `psw_load` are both high, `pc_val` and `psw_val` carry the `next_pc` and `cur_psw` saved at entry, and `svc_lvl` returns to its saved value.
- R7: In the sequential mode (`nest_mode`=0), no request is acknowledged while `svc_lvl` is not idle. A request held across the handler is accepted at the first boundary after the return.
- R8: In the nested mode (`nest_mode`=1), a request from a line with a lower index than `svc_lvl` preempts the handler. Requests from lines with an equal or higher index wait.
- R9: When `rti` and an eligible request meet at the same boundary, the return is performed and the request is not acknowledged in that cycle.
- R10: An entry attempted while the stack holds STK_DEPTH frames sets `err_ovf`, which stays set until reset. That attempt produces no acknowledge and no load.
- R11: A return with an empty stack sets `err_unf`, which stays set until reset. That return produces no load strobe.
- R12: Nested frames are restored in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nest_mode | input | 1 | 0 = sequential handling, 1 = priority nesting |
| irq_req | input | NUM_SRC | Level-sensitive request lines; bit 0 has the highest priority |
| insn_done | input | 1 | Instruction boundary marker from the core |
| rti | input | 1 | Return-from-interrupt command, valid with insn_done |
| next_pc | input | PC_W | Address of the next instruction, saved on entry |
| cur_psw | input | PSW_W | Current status word, saved on entry |
| vec_we | input | 1 | Vector table write strobe |
| vec_idx | input | SIDX_W | Vector table entry to write |
| vec_data | input | PC_W | Handler entry address to store |
| irq_ack | output | NUM_SRC | One-hot acknowledge pulse |
| pc_load | output | 1 | Core must load pc_val into its program counter |
| pc_val | output | PC_W | Handler address or restored return address |
| psw_load | output | 1 | Core must load psw_val into its status word |
| psw_val | output | PSW_W | Restored status word |
| svc_lvl | output | LVL_W | Line now in service, NUM_SRC when idle |
| err_ovf | output | 1 | Sticky stack overflow flag |
| err_unf | output | 1 | Sticky stack underflow flag |

## Verification
The bench targets the following cases, each paired with the fault it would expose:
- Requests that arrive with no boundary. A sequencer that ignored `insn_done` would acknowledge them at once.
- A higher-priority line raised during a sequential-mode handler. A design that left it unmasked would preempt, and one that lost it would never serve it after the return.
- Nesting: a strictly higher line must preempt, while equal and lower lines must wait. A wrong comparison shows up as an early or a missing acknowledge.
- Stack limits: the frames are filled to the limit and then overrun, and a return is issued with nothing on the stack. Swapped restore order, non-sticky error flags, or a redirect issued despite the error would each be caught.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   // action taken at one instruction boundary
   typedef enum logic [2:0] {
      ACT_NONE   = 3'd0,
      ACT_ENTER  = 3'd1,
      ACT_RETURN = 3'd2,
      ACT_OVF    = 3'd3,
      ACT_UNF    = 3'd4
   } seq_act_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          valid,
   output logic [IW-1:0] idx
);
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      // scan from the top down so the lowest index is the last one written
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            valid = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
   parameter int N  = 4,
   parameter int AW = 12,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [AW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [AW-1:0] rdata
);
   logic [AW-1:0] ent [N];

   for (genvar g = 0; g < N; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent[g] <= '0;
         else if (we && (widx == IW'(g)))
            ent[g] <= wdata;
      end
   end

   assign rdata = ent[ridx];
endmodule

// File: rtl/irq_ctrl_stack.sv
module irq_ctrl_stack #(
   parameter int W     = 23,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [CW-1:0] cnt;
   logic [IW-1:0] top_idx;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign top_idx = IW'(cnt - CW'(1));
   assign dout    = empty ? '0 : mem[top_idx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (push && !full && (cnt == CW'(g)))
            mem[g] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (push && !full)
         cnt <= cnt + CW'(1);
      else if (pop && !empty)
         cnt <= cnt - CW'(1);
   end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
   import irq_seq_pkg::*;
#(
   parameter int NUM_SRC   = 4,
   parameter int PC_W      = 12,
   parameter int PSW_W     = 8,
   parameter int STK_DEPTH = 2,
   localparam int SIDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int LVL_W    = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               nest_mode,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               insn_done,
   input  logic               rti,
   input  logic [PC_W-1:0]    next_pc,
   input  logic [PSW_W-1:0]   cur_psw,
   input  logic               vec_we,
   input  logic [SIDX_W-1:0]  vec_idx,
   input  logic [PC_W-1:0]    vec_data,
   output logic [NUM_SRC-1:0] irq_ack,
   output logic               pc_load,
   output logic [PC_W-1:0]    pc_val,
   output logic               psw_load,
   output logic [PSW_W-1:0]   psw_val,
   output logic [LVL_W-1:0]   svc_lvl,
   output logic               err_ovf,
   output logic               err_unf
);
   localparam int FW = PC_W + PSW_W + LVL_W;
   localparam logic [LVL_W-1:0] IDLE = LVL_W'(NUM_SRC);

   if (NUM_SRC < 1) begin : g_bad_src
      $error("NUM_SRC must be at least 1");
   end
   if (STK_DEPTH < 1) begin : g_bad_depth
      $error("STK_DEPTH must be at least 1");
   end
   if (PC_W < 1 || PSW_W < 1) begin : g_bad_width
      $error("PC_W and PSW_W must be positive");
   end

   logic              pick_vld;
   logic [SIDX_W-1:0] pick_idx;
   logic [PC_W-1:0]   vec_addr;
   logic [FW-1:0]     frm_in, frm_out;
   logic              stk_full, stk_empty;
   logic              eligible;
   seq_act_e          act;

   irq_prio_pick #(.N(NUM_SRC), .IW(SIDX_W)) i_pick (
      .req   (irq_req),
      .valid (pick_vld),
      .idx   (pick_idx)
   );

   irq_vec_table #(.N(NUM_SRC), .AW(PC_W), .IW(SIDX_W)) i_vec (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (vec_we),
      .widx  (vec_idx),
      .wdata (vec_data),
      .ridx  (pick_idx),
      .rdata (vec_addr)
   );

   assign frm_in = {next_pc, cur_psw, svc_lvl};

   irq_ctrl_stack #(.W(FW), .DEPTH(STK_DEPTH)) i_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (act == ACT_ENTER),
      .pop   (act == ACT_RETURN),
      .din   (frm_in),
      .dout  (frm_out),
      .full  (stk_full),
      .empty (stk_empty)
   );

   // sequential: only while idle; nested: strictly higher priority than current
   always_comb begin
      if (nest_mode)
         eligible = pick_vld && (LVL_W'(pick_idx) < svc_lvl);
      else
         eligible = pick_vld && (svc_lvl == IDLE);
   end

   always_comb begin
      act = ACT_NONE;
      if (insn_done) begin
         if (rti)
            act = stk_empty ? ACT_UNF : ACT_RETURN;
         else if (eligible)
            act = stk_full ? ACT_OVF : ACT_ENTER;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_ack  <= '0;
         pc_load  <= 1'b0;
         pc_val   <= '0;
         psw_load <= 1'b0;
         psw_val  <= '0;
         svc_lvl  <= IDLE;
         err_ovf  <= 1'b0;
         err_unf  <= 1'b0;
      end else begin
         irq_ack  <= '0;
         pc_load  <= 1'b0;
         psw_load <= 1'b0;
         case (act)
            ACT_ENTER: begin
               irq_ack <= NUM_SRC'(1) << pick_idx;
               pc_load <= 1'b1;
               pc_val  <= vec_addr;
               svc_lvl <= LVL_W'(pick_idx);
            end
            ACT_RETURN: begin
               pc_load  <= 1'b1;
               pc_val   <= frm_out[FW-1 -: PC_W];
               psw_load <= 1'b1;
               psw_val  <= frm_out[LVL_W +: PSW_W];
               svc_lvl  <= frm_out[LVL_W-1:0];
            end
            ACT_OVF: err_ovf <= 1'b1;
            ACT_UNF: err_unf <= 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int NUM_SRC = 4,
   parameter int LVL_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               nest_mode,
   input logic [NUM_SRC-1:0] irq_req,
   input logic               insn_done,
   input logic [NUM_SRC-1:0] irq_ack,
   input logic               pc_load,
   input logic               psw_load,
   input logic [LVL_W-1:0]   svc_lvl,
   input logic               err_ovf,
   input logic               err_unf
);
   localparam logic [LVL_W-1:0] IDLE = LVL_W'(NUM_SRC);

   // R3
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));

   // R3
   ack_has_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> (pc_load && !psw_load));

   // R3
   ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_done |=> ((irq_ack & ~$past(irq_req)) == '0) || 1'b1 && (irq_ack == '0));

   // R2
   no_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_done |=> (irq_ack == '0 && !pc_load && !psw_load));

   // R6
   psw_with_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psw_load |-> pc_load);

   // R7
   seq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nest_mode && svc_lvl != IDLE) |=> (irq_ack == '0));

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_ovf |=> err_ovf);

   // R11
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_unf |=> err_unf);
endmodule

bind irq_sequencer irq_seq_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .nest_mode (nest_mode),
   .irq_req   (irq_req),
   .insn_done (insn_done),
   .irq_ack   (irq_ack),
   .pc_load   (pc_load),
   .psw_load  (psw_load),
   .svc_lvl   (svc_lvl),
   .err_ovf   (err_ovf),
   .err_unf   (err_unf)
);

// File: tb/test_irq_sequencer.sv
`timescale 1ns/1ps
module test_irq_sequencer;
   localparam int N  = 4;
   localparam int PW = 12;
   localparam int SW = 8;
   localparam int LW = 3;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nest_mode = 1'b0;
   logic [N-1:0]  irq_req = '0;
   logic          insn_done = 1'b0;
   logic          rti = 1'b0;
   logic [PW-1:0] next_pc = '0;
   logic [SW-1:0] cur_psw = '0;
   logic          vec_we = 1'b0;
   logic [IW-1:0] vec_idx = '0;
   logic [PW-1:0] vec_data = '0;
   logic [N-1:0]  irq_ack;
   logic          pc_load;
   logic [PW-1:0] pc_val;
   logic          psw_load;
   logic [SW-1:0] psw_val;
   logic [LW-1:0] svc_lvl;
   logic          err_ovf;
   logic          err_unf;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_sequencer i_irq_sequencer (
      .clk(clk), .rst_n(rst_n), .nest_mode(nest_mode), .irq_req(irq_req),
      .insn_done(insn_done), .rti(rti), .next_pc(next_pc), .cur_psw(cur_psw),
      .vec_we(vec_we), .vec_idx(vec_idx), .vec_data(vec_data),
      .irq_ack(irq_ack), .pc_load(pc_load), .pc_val(pc_val),
      .psw_load(psw_load), .psw_val(psw_val), .svc_lvl(svc_lvl),
      .err_ovf(err_ovf), .err_unf(err_unf)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one boundary edge; returns at the following falling edge for sampling
   task automatic boundary(input logic do_rti);
      insn_done = 1'b1;
      rti       = do_rti;
      @(posedge clk);
      @(negedge clk);
      insn_done = 1'b0;
      rti       = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 ack", 32'(irq_ack), 0);
      chk("R1 pc_load", 32'(pc_load), 0);
      chk("R1 psw_load", 32'(psw_load), 0);
      chk("R1 lvl", 32'(svc_lvl), 4);
      chk("R1 ovf", 32'(err_ovf), 0);
      chk("R1 unf", 32'(err_unf), 0);
   endtask

   task automatic t_vec_load;
      for (int i = 0; i < N; i++) begin
         vec_we = 1'b1; vec_idx = IW'(i); vec_data = PW'(12'h100 + i * 12'h40);
         @(negedge clk);
      end
      vec_we = 1'b0;
   endtask

   task automatic t_gate;
      irq_req = 4'b0010;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R2 ack", 32'(irq_ack), 0);
         chk("R2 pc_load", 32'(pc_load), 0);
      end
   endtask

   task automatic t_seq;
      nest_mode = 1'b0;
      irq_req = 4'b0110; next_pc = 12'h300; cur_psw = 8'hA5;
      boundary(1'b0);
      chk("R3 R4 ack", 32'(irq_ack), 32'b0010);
      chk("R3 pc_load", 32'(pc_load), 1);
      chk("R5 pc_val", 32'(pc_val), 32'h140);
      chk("R5 lvl", 32'(svc_lvl), 1);
      @(negedge clk);
      chk("R3 pulse", 32'(irq_ack), 0);
      irq_req = 4'b0101; next_pc = 12'h555; cur_psw = 8'h00;
      boundary(1'b0);
      chk("R7 masked", 32'(irq_ack), 0);
      chk("R7 lvl", 32'(svc_lvl), 1);
      boundary(1'b1);
      chk("R9 no ack", 32'(irq_ack), 0);
      chk("R6 pc_load", 32'(pc_load), 1);
      chk("R6 psw_load", 32'(psw_load), 1);
      chk("R6 pc_val", 32'(pc_val), 32'h300);
      chk("R6 psw_val", 32'(psw_val), 32'hA5);
      chk("R6 lvl", 32'(svc_lvl), 4);
      boundary(1'b0);
      chk("R7 pending taken", 32'(irq_ack), 32'b0001);
      chk("R5 pc_val line0", 32'(pc_val), 32'h100);
      irq_req = 4'b0100;
      boundary(1'b1);
      boundary(1'b0);
      chk("R4 line2", 32'(irq_ack), 32'b0100);
      chk("R5 pc_val line2", 32'(pc_val), 32'h180);
      irq_req = 4'b0000;
      boundary(1'b1);
      chk("R6 idle", 32'(svc_lvl), 4);
   endtask

   task automatic t_nest;
      nest_mode = 1'b1;
      irq_req = 4'b0100; next_pc = 12'h010; cur_psw = 8'h11;
      boundary(1'b0);
      chk("R8 first", 32'(irq_ack), 32'b0100);
      irq_req = 4'b1000;
      boundary(1'b0);
      chk("R8 lower waits", 32'(irq_ack), 0);
      irq_req = 4'b1100;
      boundary(1'b0);
      chk("R8 equal waits", 32'(irq_ack), 0);
      irq_req = 4'b1010; next_pc = 12'h020; cur_psw = 8'h22;
      boundary(1'b0);
      chk("R8 preempt", 32'(irq_ack), 32'b0010);
      chk("R8 pc_val", 32'(pc_val), 32'h140);
      chk("R8 lvl", 32'(svc_lvl), 1);
      irq_req = 4'b1001; next_pc = 12'h030; cur_psw = 8'h33;
      boundary(1'b0);
      chk("R10 no ack", 32'(irq_ack), 0);
      chk("R10 no load", 32'(pc_load), 0);
      chk("R10 ovf", 32'(err_ovf), 1);
      irq_req = 4'b1000;
      boundary(1'b1);
      chk("R12 pc first", 32'(pc_val), 32'h020);
      chk("R12 psw first", 32'(psw_val), 32'h22);
      chk("R12 lvl first", 32'(svc_lvl), 2);
      boundary(1'b1);
      chk("R12 pc second", 32'(pc_val), 32'h010);
      chk("R12 psw second", 32'(psw_val), 32'h11);
      chk("R12 lvl second", 32'(svc_lvl), 4);
      boundary(1'b0);
      chk("R8 lowest served", 32'(irq_ack), 32'b1000);
      irq_req = 4'b0000;
      boundary(1'b1);
      chk("R10 sticky", 32'(err_ovf), 1);
   endtask

   task automatic t_unf;
      boundary(1'b1);
      chk("R11 unf", 32'(err_unf), 1);
      chk("R11 no pc_load", 32'(pc_load), 0);
      chk("R11 no psw_load", 32'(psw_load), 0);
      @(negedge clk);
      @(negedge clk);
      chk("R11 sticky", 32'(err_unf), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_vec_load();
      t_gate();
      t_seq();
      t_nest();
      t_unf();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule